// File: doc/BRIEF.md
# Fifteen-Source Prioritised Interrupt Controller

The block gathers fifteen interrupt request lines, numbered 1 to 15, into a pending register. It masks them and presents the highest-numbered unmasked pending request to the processor as a 4-bit level, together with a trap type equal to 0x10 plus that level. Throughout the design, a source's number is also its bit position in every register and its priority. Software works the block through a small word-addressed register port. Through that port it selects edge or level detection per source, reads the pending bits, sets the mask, drops pending bits with one-per-bit clear writes, and injects interrupts for testing once a test enable is set. When the processor accepts a level it pulses an acknowledge with that level, and the matching pending bit is dropped.

A two-state presenter drives the processor side. In ST_IDLE no level is shown. The transition "raise" moves to ST_REQ when any unmasked request is pending and latches the winner. In ST_REQ the transition "retarget" follows a higher or changed winner. The transition "taken" returns to ST_IDLE on an acknowledge. The transition "withdraw" returns to ST_IDLE when masking or clearing leaves nothing to present. After an acknowledge the level reads 0 for one cycle before the next request is raised.

Top module: `irq_ctrl15`

## Requirements
- R1: After reset the pending, mask and shape registers and the test enable read 0, irq_req is 0, irq_level is 0 and irq_trap is 0.
- R2: With a shape bit of 0 (edge mode, the reset default), a 0-to-1 change on a source sets its pending bit at the next clock edge. Holding the line high sets it no further, even after the bit has been cleared.
- R3: With a shape bit of 1 (level mode), the pending bit is set at every clock edge while the source is high, and it stays cleared once the line is low and a clear has been written.
- R4: Writing the clear register (address 3) removes each pending bit whose data bit is 1. Data bits of 0 leave their pending bits unchanged.
- R5: A source event at the same clock edge as a clear or an acknowledge of that bit leaves the bit pending.
- R6: A mask bit of 1 (mask register, address 2) keeps that source out of the presented level, while its pending bit is still recorded and readable.
- R7: Writing the force register (address 4) sets the pending bits whose data bits are 1, but only while the test enable (bit 19 of the test register, address 5) is 1. Otherwise the write has no effect.
- R8: irq_level shows the highest-numbered source that is both pending and unmasked, one clock edge after that state is registered. It shows 0 when no such source exists. irq_req is 1 exactly when irq_level is nonzero.
- R9: irq_trap equals 0x10 plus irq_level while irq_req is 1, and 0 otherwise.
- R10: A cycle with irq_ack high clears the pending bit numbered irq_ack_lvl, and makes irq_req and irq_level 0 after that edge.
- R11: Register addresses: 0 shape, 1 pending (read only), 2 mask, 3 clear, 4 force, 5 test. Reads of 3, 4 and unused addresses return 0. Bit 0 of every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 15 | Request lines, bit n is source n |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_ack | input | 1 | Processor acknowledge pulse |
| irq_ack_lvl | input | 4 | Level being acknowledged |
| irq_req | output | 1 | A request is being presented |
| irq_level | output | 4 | Presented request level |
| irq_trap | output | 8 | Trap type of presented request |

## Verification
On every cycle, the assertions check these properties: the presented level matches a pending unmasked source with no higher one beside it; irq_req agrees with the level; an acknowledge always drops the request; a source event is never lost to a same-edge clear; and no pending bit appears without an event or an enabled force. Other behaviour only shows up in the bench's scenarios against its reference model, which mixes directed cases with random traffic. That covers the edge/level shaping differences, per-bit clear selectivity, the force gating by the test bit, the trap numbering and the register read map.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Register word addresses
    typedef enum logic [2:0] {
        A_SHAPE = 3'd0,
        A_PEND  = 3'd1,
        A_MASK  = 3'd2,
        A_CLEAR = 3'd3,
        A_FORCE = 3'd4,
        A_TEST  = 3'd5
    } regsel_e;

    // Presenter states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } pres_st_e;

    localparam logic [7:0] TRAP_BASE = 8'h10;

endpackage

// File: rtl/irqc_shaper.sv
module irqc_shaper #(
    parameter int NSRC = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC:0]   src,
    input  logic [NSRC:0]   shape,
    output logic [NSRC:0]   evt
);
    logic [NSRC:0] src_q;

    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src;
    end

    // shape 0: rising edge, shape 1: high level
    for (genvar i = 0; i <= NSRC; i++) begin : g_src
        if (i == 0) begin : g_none
            assign evt[i] = 1'b0;
        end else begin : g_det
            assign evt[i] = shape[i] ? src[i] : (src[i] & ~src_q[i]);
        end
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NSRC      = 15,
    parameter int DW        = 32,
    parameter int FORCE_BIT = 19
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [2:0]      addr,
    input  logic [DW-1:0]   wdata,
    input  logic [NSRC:0]   evt,
    input  logic [NSRC:0]   ack_clr,
    output logic [DW-1:0]   rdata,
    output logic [NSRC:0]   pend,
    output logic [NSRC:0]   mask,
    output logic [NSRC:0]   shape,
    output logic            force_hit
);
    localparam logic [NSRC:0] USED = {{NSRC{1'b1}}, 1'b0};

    logic [NSRC:0] pend_q, mask_q, shape_q;
    logic          tst_q;
    logic [NSRC:0] wvec, clr, frc, pend_d;

    assign wvec      = wdata[NSRC:0] & USED;
    assign force_hit = wr && (addr == A_FORCE) && tst_q;
    assign clr       = (wr && (addr == A_CLEAR)) ? wvec : '0;
    assign frc       = force_hit ? wvec : '0;
    // new events and forces take precedence over removal
    assign pend_d    = ((pend_q & ~clr & ~ack_clr) | evt | frc) & USED;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            mask_q  <= '0;
            shape_q <= '0;
            tst_q   <= 1'b0;
        end else begin
            pend_q <= pend_d;
            if (wr && addr == A_MASK)  mask_q  <= wvec;
            if (wr && addr == A_SHAPE) shape_q <= wvec;
            if (wr && addr == A_TEST)  tst_q   <= wdata[FORCE_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_SHAPE: rdata[NSRC:0]   = shape_q;
            A_PEND:  rdata[NSRC:0]   = pend_q;
            A_MASK:  rdata[NSRC:0]   = mask_q;
            A_TEST:  rdata[FORCE_BIT] = tst_q;
            default: rdata = '0;
        endcase
    end

    assign pend  = pend_q;
    assign mask  = mask_q;
    assign shape = shape_q;
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int NSRC = 15,
    parameter int LVLW = $clog2(NSRC + 1)
) (
    input  logic [NSRC:0]    cand,
    output logic [LVLW-1:0]  win,
    output logic             any
);
    always_comb begin
        win = '0;
        for (int i = 1; i <= NSRC; i++) begin
            if (cand[i]) win = LVLW'(i);
        end
    end
    assign any = |cand[NSRC:1];
endmodule

// File: rtl/irq_ctrl15.sv
module irq_ctrl15
    import irqc_pkg::*;
#(
    parameter int NSRC      = 15,
    parameter int DW        = 32,
    parameter int FORCE_BIT = 19,
    localparam int LVLW     = $clog2(NSRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC:1]    irq_src,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             irq_ack,
    input  logic [LVLW-1:0]  irq_ack_lvl,
    output logic             irq_req,
    output logic [LVLW-1:0]  irq_level,
    output logic [7:0]       irq_trap
);
    logic [NSRC:0]   src_v, evt, pend_q, mask_q, shape_q, ack_clr, cand;
    logic            force_hit, any;
    logic [LVLW-1:0] win, lvl_q, lvl_d;
    pres_st_e        state_q, state_d;

    assign src_v = {irq_src, 1'b0};

    for (genvar i = 0; i <= NSRC; i++) begin : g_ack
        if (i == 0) begin : g_z
            assign ack_clr[i] = 1'b0;
        end else begin : g_a
            assign ack_clr[i] = irq_ack && (irq_ack_lvl == LVLW'(i));
        end
    end

    irqc_shaper #(.NSRC(NSRC)) u_shaper (
        .clk(clk), .rst_n(rst_n), .src(src_v), .shape(shape_q), .evt(evt)
    );

    irqc_regs #(.NSRC(NSRC), .DW(DW), .FORCE_BIT(FORCE_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .evt(evt), .ack_clr(ack_clr), .rdata(reg_rdata),
        .pend(pend_q), .mask(mask_q), .shape(shape_q), .force_hit(force_hit)
    );

    assign cand = pend_q & ~mask_q;

    irqc_prio #(.NSRC(NSRC), .LVLW(LVLW)) u_prio (
        .cand(cand), .win(win), .any(any)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lvl_q   <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
        end
    end

    // next state: raise, retarget, taken, withdraw
    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any) begin
                    state_d = ST_REQ;
                    lvl_d   = win;
                end
            end
            ST_REQ: begin
                if (irq_ack || !any) begin
                    state_d = ST_IDLE;
                    lvl_d   = '0;
                end else begin
                    lvl_d   = win;
                end
            end
            default: begin
                state_d = ST_IDLE;
                lvl_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        irq_req   = (state_q == ST_REQ);
        irq_level = lvl_q;
        irq_trap  = (state_q == ST_REQ) ? (TRAP_BASE + 8'(lvl_q)) : 8'h00;
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NSRC = 15,
    localparam int LVLW = $clog2(NSRC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LVLW-1:0] irq_level,
    input  logic            irq_req,
    input  logic            irq_ack,
    input  logic [NSRC:0]   pend,
    input  logic [NSRC:0]   mask,
    input  logic [NSRC:0]   evt,
    input  logic            force_hit
);
    logic [NSRC:0] cand_d;

    always_ff @(posedge clk) begin
        if (!rst_n) cand_d <= '0;
        else        cand_d <= pend & ~mask;
    end

    assert_req_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (irq_level != '0));

    assert_level_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> cand_d[irq_level]);

    assert_level_highest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> ((cand_d >> irq_level) == 1));

    assert_ack_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> !irq_req);

    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> (($past(evt) & ~pend) == '0));

    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !force_hit |=> ((pend & ~$past(pend | evt)) == '0));
endmodule

bind irq_ctrl15 irqc_checker #(.NSRC(NSRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .irq_req(irq_req),
    .irq_ack(irq_ack), .pend(pend_q), .mask(mask_q), .evt(evt),
    .force_hit(force_hit)
);

// File: tb/tb_irq_ctrl15.sv
module tb_irq_ctrl15;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:1] irq_src = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd1;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_ack = 1'b0;
    logic [3:0]  irq_ack_lvl = '0;
    logic        irq_req;
    logic [3:0]  irq_level;
    logic [7:0]  irq_trap;

    int checks = 0;
    int fails  = 0;

    // reference state
    logic [15:0] m_pend = '0, m_mask = '0, m_shape = '0, m_srcq = '0;
    logic        m_ten = 1'b0, m_st = 1'b0;
    logic [3:0]  m_lvl = '0;
    logic [15:0] n_pend, n_mask, n_shape, n_srcq;
    logic        n_ten, n_st;
    logic [3:0]  n_lvl;

    always #10 clk = ~clk;

    irq_ctrl15 dut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .irq_ack_lvl(irq_ack_lvl), .irq_req(irq_req),
        .irq_level(irq_level), .irq_trap(irq_trap)
    );

    function automatic logic [3:0] top_src(input logic [15:0] c);
        logic [3:0] w = '0;
        for (int i = 1; i < 16; i++) if (c[i]) w = 4'(i);
        return w;
    endfunction

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return {16'h0, m_shape};
            3'd1: return {16'h0, m_pend};
            3'd2: return {16'h0, m_mask};
            3'd5: return {12'h0, m_ten, 19'h0};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock cycle: compare, drive, predict, commit
    task automatic step(input logic [15:0] s, input logic w, input logic [2:0] a,
                        input logic [31:0] d, input logic k, input logic [3:0] kl);
        logic [15:0] ev, wv, clr, frc, ackc, cand;
        @(negedge clk);
        check("R8 level", {28'h0, irq_level}, {28'h0, m_lvl});
        check("R8 req", {31'h0, irq_req}, {31'h0, m_st});
        check("R9 trap", {24'h0, irq_trap}, m_st ? 32'h10 + m_lvl : 32'h0);
        check("R11 read", reg_rdata, exp_read(reg_addr));
        irq_src = s[15:1]; reg_wr = w; reg_addr = a; reg_wdata = d;
        irq_ack = k; irq_ack_lvl = kl;
        s[0] = 1'b0;
        ev   = (m_shape & s) | (~m_shape & s & ~m_srcq);
        ev[0] = 1'b0;
        wv   = d[15:0] & 16'hFFFE;
        clr  = (w && a == 3'd3) ? wv : '0;
        frc  = (w && a == 3'd4 && m_ten) ? wv : '0;
        ackc = k ? ((16'h1 << kl) & 16'hFFFE) : '0;
        n_pend  = (m_pend & ~clr & ~ackc) | ev | frc;
        n_shape = (w && a == 3'd0) ? wv : m_shape;
        n_mask  = (w && a == 3'd2) ? wv : m_mask;
        n_ten   = (w && a == 3'd5) ? d[19] : m_ten;
        n_srcq  = s;
        cand = m_pend & ~m_mask;
        n_st = m_st; n_lvl = m_lvl;
        if (!m_st) begin
            if (cand != 0) begin n_st = 1'b1; n_lvl = top_src(cand); end
        end else if (k || cand == 0) begin
            n_st = 1'b0; n_lvl = '0;
        end else n_lvl = top_src(cand);
        @(posedge clk);
        m_pend = n_pend; m_shape = n_shape; m_mask = n_mask; m_ten = n_ten;
        m_srcq = n_srcq; m_st = n_st; m_lvl = n_lvl;
        #2;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] s;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        // R1 reset state
        check("R1 level", {28'h0, irq_level}, 32'h0);
        check("R1 trap", {24'h0, irq_trap}, 32'h0);
        reg_addr = 3'd1; #1 check("R1 pend", reg_rdata, 32'h0);
        reg_addr = 3'd2; #1 check("R1 mask", reg_rdata, 32'h0);
        reg_addr = 3'd0; #1 check("R1 shape", reg_rdata, 32'h0);
        reg_addr = 3'd5; #1 check("R1 test", reg_rdata, 32'h0);
        reg_addr = 3'd1;

        // R2 edge detect
        step(16'h0010, 0, 3'd1, 0, 0, 0);
        check("R2 edge sets", reg_rdata, 32'h10);
        step(16'h0010, 0, 3'd1, 0, 0, 0);
        check("R8 level4", {28'h0, irq_level}, 32'h4);
        check("R9 trap14", {24'h0, irq_trap}, 32'h14);
        // R4 selective clear while source 12 rises
        step(16'h1010, 1, 3'd3, 32'h10, 0, 0);
        check("R11 clear reads 0", reg_rdata, 32'h0);
        step(16'h1010, 0, 3'd1, 0, 0, 0);
        check("R4 R2 clear one bit, no re-arm", reg_rdata, 32'h1000);
        check("R8 level12", {28'h0, irq_level}, 32'hC);
        // R7 force blocked
        step(16'h1010, 1, 3'd4, 32'h8000, 0, 0);
        step(16'h1010, 0, 3'd1, 0, 0, 0);
        check("R7 force blocked", reg_rdata, 32'h1000);
        step(16'h1010, 1, 3'd5, 32'h0008_0000, 0, 0);
        step(16'h1010, 1, 3'd4, 32'h8000, 0, 0);
        step(16'h1010, 0, 3'd1, 0, 0, 0);
        check("R7 force taken", reg_rdata, 32'h9000);
        check("R8 level15", {28'h0, irq_level}, 32'hF);
        // R6 mask
        step(16'h1010, 1, 3'd2, 32'h8000, 0, 0);
        step(16'h1010, 0, 3'd1, 0, 0, 0);
        check("R6 masked level", {28'h0, irq_level}, 32'hC);
        check("R6 still pending", reg_rdata, 32'h9000);
        // R10 acknowledge
        step(16'h1010, 0, 3'd1, 0, 1, 4'd12);
        check("R10 level drops", {28'h0, irq_level}, 32'h0);
        check("R10 bit cleared", reg_rdata, 32'h8000);
        step(16'h1010, 0, 3'd1, 0, 0, 0);
        // R3 R5 level mode, clear loses to event
        step(16'h1010, 1, 3'd0, 32'h20, 0, 0);
        step(16'h1030, 1, 3'd3, 32'h20, 0, 0);
        step(16'h1030, 1, 3'd3, 32'h20, 0, 0);
        step(16'h1010, 0, 3'd1, 0, 0, 0);
        check("R5 event beats clear", reg_rdata, 32'h8020);
        step(16'h1010, 1, 3'd3, 32'h20, 0, 0);
        step(16'h1010, 0, 3'd1, 0, 0, 0);
        check("R3 level cleared", reg_rdata, 32'h8000);

        // random traffic
        s = 16'h1010;
        for (int n = 0; n < 4000; n++) begin
            logic w, k;
            logic [2:0] a;
            logic [31:0] d;
            logic [3:0] kl;
            if ($urandom_range(0, 3) == 0) s = 16'($urandom) & 16'hFFFE;
            w = ($urandom_range(0, 3) == 0);
            a = 3'($urandom_range(0, 7));
            d = $urandom;
            if (a == 3'd5 && $urandom_range(0, 1) == 1) d[19] = 1'b1;
            k = irq_req && ($urandom_range(0, 2) == 0);
            kl = ($urandom_range(0, 4) == 0) ? 4'($urandom) : irq_level;
            step(s, w, a, d, k, kl);
        end
        step(s, 0, 3'd1, 0, 0, 0);
        summary();
        $finish;
    end
endmodule